// File: doc/BRIEF.md
# SGMII Speed Rate Adapter

This block adapts a byte-wide client stream (data, enable, error) to a serial-side byte stream that always runs at one byte per clock. At gigabit speed every byte crosses unchanged. At 100 Mb/s each client byte occupies ten consecutive serial-side cycles, and at 10 Mb/s it occupies one hundred. The transmit direction stretches bytes by repeating them. The receive direction reverses this: it keeps one byte out of each group of repeats and holds it for the client for a whole group period. The repetition sits above the line coding, so the start-of-packet strobe fires once per frame and is never repeated.

A small control stage picks the active speed. The speed comes from the negotiated code, or from a forced code when negotiation is switched off. A separate blocking bit refuses 10 Mb/s. A new speed is taken only while both directions are idle. The serial path runs only while its interface enable is set. When that enable is clear, both output enables stay low.

Speed codes on `anSpeed`, `forcedSpeed` and `activeSpeed` are: 2'b00 = 10 Mb/s, 2'b01 = 100 Mb/s, 2'b10 = 1000 Mb/s. A request of 2'b11 is treated as 1000 Mb/s.

Top module: `sgmii_rate_adapter`

## Requirements
- R1: At 1000 Mb/s, `txSerData`, `txSerEn` and `txSerErr` equal the client inputs of the previous cycle.
- R2: At 100 Mb/s, the client byte present on the first cycle of each 10-cycle group is emitted on 10 consecutive cycles, one cycle later. Client data on the other 9 cycles of the group is not used. The first group of a frame begins on the cycle in which `txEn` is first seen high.
- R3: At 10 Mb/s, the same behaviour applies as in R2, with groups of 100 cycles.
- R4: `txSerSop` is high only on the first serial cycle of a frame, that is, on the first copy of the first byte, and is never repeated.
- R5: `txSerErr` takes the value of `txErr` sampled with its byte at the group start and is repeated with every copy of that byte.
- R6: On receive, the group counter restarts on the cycle `rxSerEn` rises. The first copy of each group supplies the decoded byte. The cycle after a group's last copy, `rxEn`/`rxData` present that byte and hold it for one group period. `rxEn` falls one group period after the last group of the frame.
- R7: `rxErr` is set for a decoded byte when `rxSerErr` was high on any copy of its group.
- R8: `activeSpeed` follows `anSpeed` when `anEnable` is 1, and follows `forcedSpeed` when `anEnable` is 0. The codes are those listed above, and reset selects 2'b10.
- R9: While `block10` is 1, a request for 10 Mb/s is ignored and `activeSpeed` keeps its previous value.
- R10: `activeSpeed` changes only while no frame is in progress: `txEn` and `rxSerEn` low, both output enables low, and no group partly done.
- R11: While `sgmiiEn` is 0, `txSerEn`, `txSerSop` and `rxEn` are low whatever the data inputs are.
- R12: Synchronous active-high reset clears the counters and both output enables and selects 1000 Mb/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock of the serial side |
| rst | input | 1 | Synchronous active-high reset |
| sgmiiEn | input | 1 | Serial interface enable; gates both paths |
| anEnable | input | 1 | 1: use negotiated speed; 0: use forced speed |
| anSpeed | input | 2 | Negotiated speed code |
| forcedSpeed | input | 2 | Forced (resolved) speed code |
| block10 | input | 1 | When 1, 10 Mb/s requests are refused |
| txEn | input | 1 | Client transmit enable |
| txData | input | 8 | Client transmit byte |
| txErr | input | 1 | Client transmit error |
| txSerData | output | 8 | Serial-side transmit byte |
| txSerEn | output | 1 | Serial-side transmit enable |
| txSerErr | output | 1 | Serial-side transmit error |
| txSerSop | output | 1 | Start-of-packet strobe, once per frame |
| rxSerData | input | 8 | Serial-side receive byte |
| rxSerEn | input | 1 | Serial-side receive enable |
| rxSerErr | input | 1 | Serial-side receive error |
| rxData | output | 8 | Decoded receive byte to client |
| rxEn | output | 1 | Client receive enable |
| rxErr | output | 1 | Client receive error |
| activeSpeed | output | 2 | Speed currently in use |

## Verification
The hardest case to reach is a speed request that arrives while a frame is in flight. The stimulus changes the forced speed on the same cycle that a long gigabit frame starts. It then checks that the old speed holds through every byte and that the new one appears only after the tail of the frame has drained. Group alignment is checked as well. The stimulus fills the non-first copies of every group with altered data and altered error flags, so that a counter off by even one cycle shows up as a wrong byte. Errors are placed on a middle copy at 100 Mb/s and on copy 50 at 10 Mb/s, to confirm that they collect over the whole group.

// File: rtl/rate_pkg.sv
package rate_pkg;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10
  } speed_e;

  typedef struct packed {
    logic   pathOn;
    speed_e speed;
  } rate_ctrl_t;

endpackage

// File: rtl/rate_phase.sv
module rate_phase #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] idx
);

  logic [CNT_W-1:0] cnt;

  always_comb idx = restart ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= (idx == last) ? '0 : idx + 1'b1;
    end
  end

endmodule

// File: rtl/rate_ctrl.sv
module rate_ctrl
  import rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sgmiiEn,
  input  logic       anEnable,
  input  logic [1:0] anSpeed,
  input  logic [1:0] forcedSpeed,
  input  logic       block10,
  input  logic       dpIdle,
  output rate_ctrl_t ctrl
);

  logic [1:0] reqCode;
  speed_e     reqSpeed;
  logic       honoured;
  speed_e     speedQ;

  always_comb begin
    reqCode = anEnable ? anSpeed : forcedSpeed;
    case (reqCode)
      2'b00:   reqSpeed = SPD_10;
      2'b01:   reqSpeed = SPD_100;
      default: reqSpeed = SPD_1000;
    endcase
    honoured = !((reqSpeed == SPD_10) && block10);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      speedQ <= SPD_1000;
    end else if (dpIdle && honoured) begin
      speedQ <= reqSpeed;
    end
  end

  always_comb begin
    ctrl.pathOn = sgmiiEn;
    ctrl.speed  = speedQ;
  end

  // R10: the speed register moves only after an idle cycle
  a_r10_speed_idle: assert property (@(posedge clk) disable iff (rst)
    (speedQ != $past(speedQ)) |-> $past(dpIdle));

  // R9: 10 Mb/s is never entered while the blocking bit was set
  a_r9_block_ten: assert property (@(posedge clk) disable iff (rst)
    (speedQ == SPD_10 && $past(speedQ) != SPD_10) |-> !$past(block10));

endmodule

// File: rtl/rate_datapath.sv
module rate_datapath
  import rate_pkg::*;
#(
  parameter int REP_100 = 10,
  parameter int REP_10  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  rate_ctrl_t ctrl,
  input  logic       txEn,
  input  logic [7:0] txData,
  input  logic       txErr,
  output logic [7:0] txSerData,
  output logic       txSerEn,
  output logic       txSerErr,
  output logic       txSerSop,
  input  logic [7:0] rxSerData,
  input  logic       rxSerEn,
  input  logic       rxSerErr,
  output logic [7:0] rxData,
  output logic       rxEn,
  output logic       rxErr,
  output logic       dpIdle
);

  localparam int CNT_W = $clog2(REP_10);
  localparam logic [CNT_W-1:0] LAST_100 = CNT_W'(REP_100 - 1);
  localparam logic [CNT_W-1:0] LAST_10  = CNT_W'(REP_10 - 1);

  logic [CNT_W-1:0] repLast;

  always_comb begin
    case (ctrl.speed)
      SPD_10:  repLast = LAST_10;
      SPD_100: repLast = LAST_100;
      default: repLast = '0;
    endcase
  end

  // ---------------- transmit: replicate ----------------
  logic [CNT_W-1:0] txIdx;
  logic             txRun, txTake;
  logic [7:0]       txDataQ;
  logic             txEnQ, txErrQ, txSopQ;

  assign txRun  = ctrl.pathOn && (txEn || txIdx != '0);
  assign txTake = ctrl.pathOn && (txIdx == '0);

  rate_phase #(.CNT_W(CNT_W)) u_txPhase (
    .clk     (clk),
    .rst     (rst),
    .clear   (!ctrl.pathOn),
    .restart (1'b0),
    .run     (txRun),
    .last    (repLast),
    .idx     (txIdx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txDataQ <= '0;
      txEnQ   <= 1'b0;
      txErrQ  <= 1'b0;
      txSopQ  <= 1'b0;
    end else if (!ctrl.pathOn) begin
      txEnQ  <= 1'b0;
      txErrQ <= 1'b0;
      txSopQ <= 1'b0;
    end else if (txTake) begin
      txDataQ <= txData;
      txEnQ   <= txEn;
      txErrQ  <= txEn && txErr;
      txSopQ  <= txEn && !txEnQ;
    end else begin
      txSopQ <= 1'b0;
    end
  end

  assign txSerData = txDataQ;
  assign txSerEn   = txEnQ;
  assign txSerErr  = txErrQ;
  assign txSerSop  = txSopQ;

  // ---------------- receive: decimate ----------------
  logic [CNT_W-1:0] rxIdx;
  logic             rxSerEnD, rxRise, rxRun, rxFirst, rxLast, rxHit;
  logic             grpValidQ, errAccQ;
  logic [7:0]       grpDataQ;
  logic             grpValid, grpErr;
  logic [7:0]       grpData;
  logic [7:0]       rxDataQ;
  logic             rxEnQ, rxErrQ;

  assign rxRise = rxSerEn && !rxSerEnD;
  assign rxRun  = ctrl.pathOn && (rxSerEn || rxEnQ || rxIdx != '0);

  rate_phase #(.CNT_W(CNT_W)) u_rxPhase (
    .clk     (clk),
    .rst     (rst),
    .clear   (!ctrl.pathOn),
    .restart (rxRise),
    .run     (rxRun),
    .last    (repLast),
    .idx     (rxIdx)
  );

  always_comb begin
    rxFirst  = (rxIdx == '0);
    rxLast   = (rxIdx == repLast);
    rxHit    = rxSerEn && rxSerErr;
    grpValid = rxFirst ? rxSerEn : grpValidQ;
    grpData  = rxFirst ? rxSerData : grpDataQ;
    grpErr   = (rxFirst ? 1'b0 : errAccQ) | rxHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxSerEnD  <= 1'b0;
      grpValidQ <= 1'b0;
      grpDataQ  <= '0;
      errAccQ   <= 1'b0;
      rxDataQ   <= '0;
      rxEnQ     <= 1'b0;
      rxErrQ    <= 1'b0;
    end else begin
      rxSerEnD <= rxSerEn;
      if (!ctrl.pathOn) begin
        grpValidQ <= 1'b0;
        errAccQ   <= 1'b0;
        rxEnQ     <= 1'b0;
        rxErrQ    <= 1'b0;
      end else begin
        if (rxFirst) begin
          grpValidQ <= rxSerEn;
          grpDataQ  <= rxSerData;
          errAccQ   <= rxHit;
        end else begin
          errAccQ <= errAccQ | rxHit;
        end
        if (rxLast) begin
          rxEnQ   <= grpValid;
          rxDataQ <= grpData;
          rxErrQ  <= grpValid && grpErr;
        end else if (rxRise) begin
          rxEnQ  <= 1'b0;
          rxErrQ <= 1'b0;
        end
      end
    end
  end

  assign rxData = rxDataQ;
  assign rxEn   = rxEnQ;
  assign rxErr  = rxErrQ;

  assign dpIdle = !(txEn || txEnQ || txIdx != '0 ||
                    rxSerEn || rxEnQ || rxIdx != '0);

  // R2: transmit byte and error hold between group starts
  a_r2_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (txEnQ && $past(txEnQ) && $past(txIdx) != '0) |->
      ($stable(txDataQ) && $stable(txErrQ)));

  // R4: start strobe only on the first cycle of the serial enable
  a_r4_sop_first: assert property (@(posedge clk) disable iff (rst)
    txSopQ |-> (txEnQ && !$past(txEnQ)));

  // R6: decoded byte holds until the next group closes
  a_r6_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (rxEnQ && $past(rxEnQ) && !$past(rxLast)) |->
      ($stable(rxDataQ) && $stable(rxErrQ)));

endmodule

// File: rtl/sgmii_rate_adapter.sv
module sgmii_rate_adapter
  import rate_pkg::*;
#(
  parameter int REP_100 = 10,
  parameter int REP_10  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sgmiiEn,
  input  logic       anEnable,
  input  logic [1:0] anSpeed,
  input  logic [1:0] forcedSpeed,
  input  logic       block10,
  input  logic       txEn,
  input  logic [7:0] txData,
  input  logic       txErr,
  output logic [7:0] txSerData,
  output logic       txSerEn,
  output logic       txSerErr,
  output logic       txSerSop,
  input  logic [7:0] rxSerData,
  input  logic       rxSerEn,
  input  logic       rxSerErr,
  output logic [7:0] rxData,
  output logic       rxEn,
  output logic       rxErr,
  output logic [1:0] activeSpeed
);

  rate_ctrl_t ctrl;
  logic       dpIdle;

  rate_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sgmiiEn     (sgmiiEn),
    .anEnable    (anEnable),
    .anSpeed     (anSpeed),
    .forcedSpeed (forcedSpeed),
    .block10     (block10),
    .dpIdle      (dpIdle),
    .ctrl        (ctrl)
  );

  rate_datapath #(.REP_100(REP_100), .REP_10(REP_10)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .txEn      (txEn),
    .txData    (txData),
    .txErr     (txErr),
    .txSerData (txSerData),
    .txSerEn   (txSerEn),
    .txSerErr  (txSerErr),
    .txSerSop  (txSerSop),
    .rxSerData (rxSerData),
    .rxSerEn   (rxSerEn),
    .rxSerErr  (rxSerErr),
    .rxData    (rxData),
    .rxEn      (rxEn),
    .rxErr     (rxErr),
    .dpIdle    (dpIdle)
  );

  assign activeSpeed = ctrl.speed;

  // R11: with the interface disabled both enables fall next cycle
  a_r11_gate: assert property (@(posedge clk) disable iff (rst)
    !sgmiiEn |=> (!txSerEn && !txSerSop && !rxEn));

  // R12: reset leaves both output enables low
  a_r12_reset: assert property (@(posedge clk)
    rst |=> (!txSerEn && !rxEn && activeSpeed == 2'b10));

endmodule

// File: tb/sim_sgmii_rate_adapter.sv
module sim_sgmii_rate_adapter;

  localparam int PERIOD  = 8;
  localparam int REP_100 = 10;
  localparam int REP_10  = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sgmiiEn = 1'b1, anEnable = 1'b1, block10 = 1'b0;
  logic [1:0] anSpeed = 2'b10, forcedSpeed = 2'b10;
  logic       txEn = 1'b0, txErr = 1'b0;
  logic [7:0] txData = '0;
  logic [7:0] txSerData;
  logic       txSerEn, txSerErr, txSerSop;
  logic [7:0] rxSerData = '0;
  logic       rxSerEn = 1'b0, rxSerErr = 1'b0;
  logic [7:0] rxData;
  logic       rxEn, rxErr;
  logic [1:0] activeSpeed;

  sgmii_rate_adapter #(.REP_100(REP_100), .REP_10(REP_10)) u0 (
    .clk(clk), .rst(rst), .sgmiiEn(sgmiiEn), .anEnable(anEnable),
    .anSpeed(anSpeed), .forcedSpeed(forcedSpeed), .block10(block10),
    .txEn(txEn), .txData(txData), .txErr(txErr),
    .txSerData(txSerData), .txSerEn(txSerEn), .txSerErr(txSerErr),
    .txSerSop(txSerSop), .rxSerData(rxSerData), .rxSerEn(rxSerEn),
    .rxSerErr(rxSerErr), .rxData(rxData), .rxEn(rxEn), .rxErr(rxErr),
    .activeSpeed(activeSpeed)
  );

  always #(PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // expected outputs for the cycle after the next rising edge
  logic       eTxEn = 0, eTxErr = 0, eTxSop = 0;
  logic [7:0] eTxData = '0;
  logic       eRxEn = 0, eRxErr = 0;
  logic [7:0] eRxData = '0;
  logic       checkSpd = 0;
  logic [1:0] eSpd = 2'b10;
  string      txTag = "R1", rxTag = "R6", spdTag = "R8";

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(txTag, "txSerEn", int'(txSerEn), int'(eTxEn));
    chk("R4", "txSerSop", int'(txSerSop), int'(eTxSop));
    if (eTxEn) begin
      chk(txTag, "txSerData", int'(txSerData), int'(eTxData));
      chk("R5", "txSerErr", int'(txSerErr), int'(eTxErr));
    end
    chk(rxTag, "rxEn", int'(rxEn), int'(eRxEn));
    if (eRxEn) begin
      chk(rxTag, "rxData", int'(rxData), int'(eRxData));
      chk("R7", "rxErr", int'(rxErr), int'(eRxErr));
    end
    if (checkSpd) chk(spdTag, "activeSpeed", int'(activeSpeed), int'(eSpd));
  endtask

  function automatic logic [7:0] byteVal(input logic [7:0] seed, input int b);
    return seed + 8'(b * 37);
  endfunction

  task automatic idle(input int n);
    txEn = 0; rxSerEn = 0; rxSerErr = 0; txErr = 0;
    eTxEn = 0; eTxSop = 0; eRxEn = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic speedCheck(input string tag, input logic [1:0] exp);
    idle(4);
    spdTag = tag; eSpd = exp; checkSpd = 1;
    tick();
    checkSpd = 0;
  endtask

  // transmit frame: byte b is held by the client for n cycles;
  // only the group's first cycle carries the true byte and error
  task automatic txFrame(input string tag, input int nB, input int n,
                         input logic [7:0] seed, input int errB);
    txTag = tag;
    for (int b = 0; b < nB; b++) begin
      for (int k = 0; k < n; k++) begin
        txEn   = 1;
        txData = (k == 0) ? byteVal(seed, b) : (byteVal(seed, b) ^ 8'h5A);
        txErr  = (k == 0) ? (b == errB) : (b != errB);
        eTxEn = 1; eTxData = byteVal(seed, b); eTxErr = (b == errB);
        eTxSop = (b == 0 && k == 0);
        tick();
      end
    end
    checkSpd = 0;
    txEn = 0; txErr = 0;
    eTxEn = 0; eTxSop = 0;
    for (int i = 0; i < 2 * n + 2; i++) tick();
  endtask

  // receive frame: first copy of each group carries the true byte
  task automatic rxFrame(input string tag, input int nB, input int n,
                         input logic [7:0] seed, input int errB, input int errK);
    rxTag = tag;
    for (int c = 0; c < (nB + 2) * n + 1; c++) begin
      int g;
      rxSerEn   = (c < nB * n);
      rxSerData = (c % n == 0) ? byteVal(seed, c / n) : (byteVal(seed, c / n) ^ 8'hC3);
      rxSerErr  = rxSerEn && (c / n == errB) && (c % n == errK);
      g = (c + 1) / n - 1;
      if ((c + 1) >= n && g < nB) begin
        eRxEn = 1; eRxData = byteVal(seed, g); eRxErr = (g == errB);
      end else begin
        eRxEn = 0;
      end
      tick();
    end
    rxSerEn = 0; rxSerErr = 0; eRxEn = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "txSerEn", int'(txSerEn), 0);
    chk("R12", "rxEn", int'(rxEn), 0);
    chk("R12", "activeSpeed", int'(activeSpeed), 2);
    rst = 0;
    speedCheck("R12", 2'b10);

    // R1 gigabit pass-through, R6/R7 receive at one copy per group
    txFrame("R1", 8, 1, 8'h11, 3);
    rxFrame("R6", 8, 1, 8'h20, 5, 0);

    // R8 negotiated 100 Mb/s, R2 ten copies, R7 error on a middle copy
    anSpeed = 2'b01;
    speedCheck("R8", 2'b01);
    txFrame("R2", 5, REP_100, 8'h40, 2);
    rxFrame("R6", 4, REP_100, 8'h60, 2, 7);

    // R9 refused 10 Mb/s, then allowed
    block10 = 1; anSpeed = 2'b00;
    speedCheck("R9", 2'b01);
    block10 = 0;
    speedCheck("R8", 2'b00);
    txFrame("R3", 2, REP_10, 8'h81, 1);
    rxFrame("R6", 2, REP_10, 8'h90, 1, 50);

    // R8 forced speed when negotiation is off (code 11 means 1000)
    anEnable = 0; forcedSpeed = 2'b11;
    speedCheck("R8", 2'b10);
    txFrame("R1", 3, 1, 8'hA0, 0);

    // R10 request during a frame waits for idle
    forcedSpeed = 2'b01;
    spdTag = "R10"; eSpd = 2'b10; checkSpd = 1;
    txFrame("R1", 12, 1, 8'hB5, 7);
    speedCheck("R10", 2'b01);
    txFrame("R2", 3, REP_100, 8'hC7, 5);

    // R11 interface disabled: enables stay low
    sgmiiEn = 0;
    txTag = "R11"; rxTag = "R11";
    txEn = 1; txData = 8'h33; rxSerEn = 1; rxSerData = 8'h44;
    eTxEn = 0; eTxSop = 0; eRxEn = 0;
    for (int i = 0; i < 25; i++) tick();
    txEn = 0; rxSerEn = 0;
    tick();
    sgmiiEn = 1;
    idle(3);
    txFrame("R2", 2, REP_100, 8'hD1, 9);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule